// File: doc/BRIEF.md
# Asynchronous Serial Port with 16x/13x Oversampling

This block is a byte-oriented asynchronous serial transmitter and receiver with a 16550-style register model. Software writes characters into a 16-entry transmit queue and reads received characters from a 16-entry receive queue. A line-control register sets the character length, parity and stop bits. A status register reports data availability, the transmit state and sticky receive errors. Register access uses a plain read strobe and a plain write strobe on a 3-bit address.

A 16-bit divisor produces a baud tick. Each serial bit lasts either 16 or 13 ticks, selected by a mode bit. The receiver takes its sample in the middle of each bit. A start bit is confirmed by sampling it again at mid-bit, so a low pulse shorter than half a bit is dropped as noise. Two optional flow-control modes are available. The first holds back new characters while the clear-to-send input is high. The second raises the request-to-send output when the receive queue reaches a chosen trigger level.

Register map (write / read): address 0 pushes to the transmit queue / pops the receive queue. Address 1 is line control. Address 2 is mode. Addresses 3 and 4 are the low and high bytes of the divisor. Address 5 reads line status. Reading any other address returns 0.

Top module: `uart_os`

## Requirements
- R1: After reset, line status reads 0x60, line control reads 0x03, the divisor reads 1, txd is 1 and rts_n is 0.
- R2: A character written to address 0 is sent as one low start bit, then the data bits LSB first, then the optional parity bit, then the stop bits at level 1. In loopback, reading address 0 returns the same character.
- R3: With divisor D, each bit lasts 16·D clocks when mode bit 0 is 0 and 13·D clocks when mode bit 0 is 1.
- R4: Line-control bits [1:0] set the character length to 5+value bits, and bits above that length are neither sent nor returned. Bit 2 selects two stop bits, bit 3 enables parity and bit 4 selects even parity (when clear, parity is odd).
- R5: A received parity bit that does not match the configured parity sets status bit 2. The character is still stored.
- R6: A stop bit sampled at 0 sets status bit 3. A frame in which every sampled bit is 0 also sets status bit 4 and stores 0x00. The receiver then waits for the line to return high before it looks for another start bit.
- R7: A low pulse shorter than half a bit period produces no character and sets no status bit.
- R8: When mode bit 1 is set, no new character starts while cts_n is 1. A character already in progress completes.
- R9: When mode bit 2 is set, rts_n is 1 while the receive queue holds at least the trigger level, and returns to 0 once a read brings it below. Mode bits [4:3] select trigger level 1, 4, 8 or 14.
- R10: Each queue holds 16 characters. A character that arrives while the receive queue is full is dropped and sets status bit 1.
- R11: Status bits: 0 = receive data ready, 5 = transmit queue empty, 6 = transmitter idle (queue empty and no character in progress). Reading status clears bits 1 to 4, but an error that arrives in the same cycle as that read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (pops the receive queue at address 0) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
A status read can clear the error flags in the same cycle in which the receiver completes a frame and raises a new error. To provoke this, the bench reads status on every clock while it drives a frame with bad parity. It then requires that the parity-error bit appears in exactly one of those reads: if the clear won that cycle, the bit would never appear, and if the bit were not cleared, it would appear repeatedly. A second collision, between a receive-queue pop and a receive-queue push, is judged through the request-to-send output and the order of the data read back.

// File: rtl/uart_os.sv
module uart_os #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       rd,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts_n,
  output logic       rts_n
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {RI, RS, RD} rxst_t;

  logic [4:0] lcr, mcr;
  logic [15:0] div, bcnt;
  logic [1:0] rs, cs;

  wire [3:0] nbit = 4'd5 + {2'b00, lcr[1:0]};
  wire pe = lcr[3];
  wire evp = lcr[4];
  wire [4:0] osr1 = mcr[0] ? 5'd12 : 5'd15;
  wire [4:0] mid1 = mcr[0] ? 5'd5 : 5'd7;
  wire [3:0] mlen = nbit + {3'b000, pe} + 4'd1;
  wire tick = ({1'b0, bcnt} + 17'd1) >= {1'b0, div};

  logic [AW:0] trig;
  always_comb
    case (mcr[4:3])
      2'd0: trig = (AW+1)'(1);
      2'd1: trig = (AW+1)'(4);
      2'd2: trig = (AW+1)'(8);
      default: trig = (AW+1)'(14);
    endcase

  logic [7:0] dmask;
  logic [9:0] fmask;
  always_comb begin
    for (int i = 0; i < 8; i++) dmask[i] = i < int'(nbit);
    for (int i = 0; i < 10; i++) fmask[i] = i < int'(mlen);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lcr <= 5'h03; mcr <= '0; div <= 16'd1; bcnt <= '0; rs <= '1; cs <= '1;
    end else begin
      rs <= {rs[0], rxd};
      cs <= {cs[0], cts_n};
      bcnt <= tick ? '0 : bcnt + 16'd1;
      if (wr)
        case (addr)
          3'd1: lcr <= wdata[4:0];
          3'd2: mcr <= wdata[4:0];
          3'd3: div[7:0] <= wdata;
          3'd4: div[15:8] <= wdata;
          default: ;
        endcase
    end

  // transmit queue and shifter
  logic [7:0] tmem [DEPTH];
  logic [AW-1:0] twp, trp;
  logic [AW:0] tcnt;
  logic tbusy;
  logic [11:0] tsh, tfr;
  logic [3:0] tleft;
  logic [4:0] ttk;

  wire tpush = wr && addr == 3'd0 && tcnt != FULL;
  wire [7:0] tdat = tmem[trp] & dmask;
  wire tload = tick && !tbusy && tcnt != '0 && !(mcr[1] && cs[1]);
  wire [3:0] tbits = 4'd2 + nbit + {3'b000, pe} + {3'b000, lcr[2]};

  always_comb begin
    tfr = '1;
    tfr[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < int'(nbit)) tfr[i+1] = tdat[i];
    if (pe) tfr[int'(nbit)+1] = evp ? ^tdat : ~^tdat;
  end

  always_ff @(posedge clk) if (tpush) tmem[twp] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0; tbusy <= 1'b0; tsh <= '1; tleft <= '0; ttk <= '0;
    end else begin
      if (tpush) twp <= twp + 1'b1;
      if (tload) trp <= trp + 1'b1;
      tcnt <= tcnt + (AW+1)'(tpush) - (AW+1)'(tload);
      if (tload) begin
        tbusy <= 1'b1; tsh <= tfr; tleft <= tbits - 4'd1; ttk <= '0;
      end else if (tbusy && tick) begin
        if (ttk == osr1) begin
          ttk <= '0;
          if (tleft == '0) tbusy <= 1'b0;
          else begin tsh <= {1'b1, tsh[11:1]}; tleft <= tleft - 4'd1; end
        end else ttk <= ttk + 5'd1;
      end
    end

  assign txd = tbusy ? tsh[0] : 1'b1;

  // receiver
  rxst_t rst_q;
  logic [4:0] rtk;
  logic [3:0] rbi;
  logic [9:0] rsh;
  logic hi, rdone;
  wire rx = rs[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_q <= RI; rtk <= '0; rbi <= '0; rsh <= '0; hi <= 1'b0; rdone <= 1'b0;
    end else begin
      rdone <= 1'b0;
      if (tick)
        case (rst_q)
          RI: if (rx) hi <= 1'b1;
              else if (hi) begin rst_q <= RS; rtk <= '0; hi <= 1'b0; end
          RS: if (rtk == mid1) begin
                rst_q <= rx ? RI : RD; rtk <= '0; rbi <= '0;
              end else rtk <= rtk + 5'd1;
          default:
              if (rtk == osr1) begin
                rtk <= '0; rsh[rbi] <= rx; rbi <= rbi + 4'd1;
                if (rbi == mlen - 4'd1) begin rdone <= 1'b1; rst_q <= RI; end
              end else rtk <= rtk + 5'd1;
        endcase
    end

  wire [7:0] rd8 = rsh[7:0] & dmask;
  wire rpar = rsh[int'(nbit)];
  wire rstop = rsh[int'(nbit) + int'(pe)];
  wire perr = pe && (rpar != (evp ? ^rd8 : ~^rd8));
  wire ferr = !rstop;
  wire brk = ferr && ((rsh & fmask) == '0);

  logic [7:0] rmem [DEPTH];
  logic [AW-1:0] rwp, rrp;
  logic [AW:0] rcnt;
  logic ovr, perf, ferf, brkf;
  wire rpush = rdone && rcnt != FULL;
  wire rpop = rd && addr == 3'd0 && rcnt != '0;
  wire lsrd = rd && addr == 3'd5;

  always_ff @(posedge clk) if (rpush) rmem[rwp] <= rd8;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0; ovr <= 1'b0; perf <= 1'b0; ferf <= 1'b0; brkf <= 1'b0;
    end else begin
      if (rpush) rwp <= rwp + 1'b1;
      if (rpop) rrp <= rrp + 1'b1;
      rcnt <= rcnt + (AW+1)'(rpush) - (AW+1)'(rpop);
      if (lsrd) begin ovr <= 1'b0; perf <= 1'b0; ferf <= 1'b0; brkf <= 1'b0; end
      if (rdone) begin
        if (rcnt == FULL) ovr <= 1'b1;
        if (perr) perf <= 1'b1;
        if (ferr) ferf <= 1'b1;
        if (brk) brkf <= 1'b1;
      end
    end

  wire [7:0] lsr = {1'b0, tcnt == '0 && !tbusy, tcnt == '0, brkf, ferf, perf, ovr, rcnt != '0};

  always_comb
    case (addr)
      3'd0: rdata = rmem[rrp];
      3'd1: rdata = {3'b000, lcr};
      3'd2: rdata = {3'b000, mcr};
      3'd3: rdata = div[7:0];
      3'd4: rdata = div[15:8];
      3'd5: rdata = lsr;
      default: rdata = 8'h00;
    endcase

  assign rts_n = mcr[2] && rcnt >= trig;
endmodule

module uart_os_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        txd,
  input logic        tbusy,
  input logic        tload,
  input logic        cts_s,
  input logic [4:0]  mcr,
  input logic        rts_n,
  input logic        rpop,
  input logic [AW:0] tcnt,
  input logic [AW:0] rcnt
);
  a_r8_cts_holds_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr[1] && cts_s && !tbusy) |=> !tbusy);

  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    tload |=> !txd);

  a_r10_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt <= (AW+1)'(DEPTH)) && (tcnt <= (AW+1)'(DEPTH)));

  a_r9_rts_only_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts_n) && $stable(mcr)) |-> $past(rpop));

  a_r11_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == '0 && !tbusy) |=> !tbusy);
endmodule

bind uart_os uart_os_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tbusy(tbusy), .tload(tload),
  .cts_s(cs[1]), .mcr(mcr), .rts_n(rts_n), .rpop(rpop), .tcnt(tcnt), .rcnt(rcnt)
);

// File: tb/sim_uart_os.sv
module sim_uart_os;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, rts_n;
  logic cts_n = 1'b0;
  logic loop = 1'b1, drv = 1'b1;
  wire rxd = loop ? txd : drv;

  int checks = 0, errors = 0;
  bit done = 0;
  byte unsigned expq[$];

  always #2 clk = ~clk;

  uart_os u0 (.clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
              .rdata(rdata), .rxd(rxd), .txd(txd), .cts_n(cts_n), .rts_n(rts_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic [7:0] m);
    wreg(3'd0, d); expq.push_back(d & m);
  endtask

  task automatic take(input string req);
    logic [7:0] d;
    rreg(3'd0, d);
    chk(req, d, expq.pop_front());
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line(input logic [11:0] bits, input int nb, input int bt);
    for (int i = 0; i < nb; i++) begin drv = bits[i]; repeat (bt) @(negedge clk); end
    drv = 1'b1;
  endtask

  task automatic lowwidth(output int w);
    w = 0;
    while (txd) @(negedge clk);
    while (!txd) begin w++; @(negedge clk); end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int w, seen;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rreg(3'd5, v); chk("R1 status", v, 8'h60);
    rreg(3'd1, v); chk("R1 line control", v, 8'h03);
    rreg(3'd3, v); chk("R1 divisor", v, 8'h01);
    chk("R1 txd", txd, 1);
    chk("R1 rts_n", rts_n, 0);

    // R2 loopback 8N1
    send(8'hA5, 8'hFF); send(8'h3C, 8'hFF);
    idle(400);
    rreg(3'd5, v); chk("R2 status after two chars", v, 8'h61);
    take("R2 first char"); take("R2 second char");
    rreg(3'd5, v); chk("R2 status drained", v, 8'h60);

    // R3 bit width, divisor 2
    wreg(3'd3, 8'd2);
    send(8'h01, 8'hFF);
    lowwidth(w); chk("R3 16x start bit width", w, 32);
    idle(400); take("R3 16x data");
    wreg(3'd2, 8'h01);
    send(8'h01, 8'hFF);
    lowwidth(w); chk("R3 13x start bit width", w, 26);
    idle(300); take("R3 13x data");
    wreg(3'd3, 8'd1);

    // R4 7E1 at 13x, and masking of the top bit
    wreg(3'd1, 8'h1A);
    send(8'h5A, 8'h7F); send(8'hC3, 8'h7F);
    idle(350);
    rreg(3'd5, v); chk("R4 7E1 status clean", v, 8'h61);
    take("R4 7E1 char"); take("R4 7E1 masked char");
    // R4 5 bits, two stop bits, 16x
    wreg(3'd2, 8'h00); wreg(3'd1, 8'h04);
    send(8'hFF, 8'h1F); send(8'h0A, 8'h1F);
    idle(350);
    take("R4 5-bit masked"); take("R4 5-bit char");
    // R4 8O1
    wreg(3'd1, 8'h0B);
    send(8'h01, 8'hFF); send(8'h7E, 8'hFF);
    idle(400);
    rreg(3'd5, v); chk("R4 8O1 status clean", v, 8'h61);
    take("R4 8O1 char a"); take("R4 8O1 char b");

    // R5 and R11: parity error while reading status on every cycle
    wreg(3'd1, 8'h1A);
    loop = 1'b0;
    idle(20);
    seen = 0;
    fork
      line({2'b11, 7'h12, 1'b0}, 10, 16);
      begin
        @(negedge clk); addr = 3'd5; rd = 1'b1;
        repeat (220) begin #1 if (rdata[2]) seen++; @(negedge clk); end
        rd = 1'b0;
      end
    join
    chk("R5 R11 parity flag seen exactly once under polling", seen, 1);
    rreg(3'd0, v); chk("R5 char kept despite parity error", v, 8'h12);

    // R6 framing error
    wreg(3'd1, 8'h03);
    line({1'b0, 8'h55, 1'b0}, 10, 16);
    idle(60);
    rreg(3'd5, v); chk("R6 framing status", v, 8'h69);
    rreg(3'd0, v); chk("R6 framing char", v, 8'h55);
    rreg(3'd5, v); chk("R11 flags cleared by read", v, 8'h60);

    // R6 break
    drv = 1'b0; idle(400); drv = 1'b1; idle(60);
    rreg(3'd5, v); chk("R6 break status", v, 8'h79);
    rreg(3'd0, v); chk("R6 break char", v, 8'h00);
    rreg(3'd5, v); chk("R6 single char for break", v, 8'h60);

    // R7 glitch
    drv = 1'b0; idle(5); drv = 1'b1; idle(300);
    rreg(3'd5, v); chk("R7 glitch ignored", v, 8'h60);
    loop = 1'b1;

    // R10 overrun
    for (int i = 0; i < 16; i++) send(8'(i * 13 + 7), 8'hFF);
    idle(2700);
    wreg(3'd0, 8'hEE);
    idle(220);
    rreg(3'd5, v); chk("R10 overrun status", v, 8'h63);
    for (int i = 0; i < 16; i++) take("R10 queued char order");
    rreg(3'd5, v); chk("R10 queue drained", v, 8'h60);

    // R8 auto-CTS blocks start
    wreg(3'd2, 8'h02);
    cts_n = 1'b1; idle(4);
    send(8'h77, 8'hFF);
    w = 0;
    repeat (300) begin @(negedge clk); if (!txd) w++; end
    chk("R8 no start while cts high", w, 0);
    rreg(3'd5, v); chk("R8 status while held", v, 8'h00);
    cts_n = 1'b0; idle(220);
    rreg(3'd5, v); chk("R8 released status", v, 8'h61);
    take("R8 released char");
    // R8 character in progress completes
    send(8'h11, 8'hFF); send(8'h22, 8'hFF);
    idle(30); cts_n = 1'b1;
    idle(400);
    rreg(3'd5, v); chk("R8 second held, first done", v, 8'h01);
    take("R8 in-progress char");
    cts_n = 1'b0; idle(220);
    take("R8 held char after release");

    // R9 auto-RTS, trigger level 4
    wreg(3'd2, 8'h0C);
    send(8'h31, 8'hFF); send(8'h32, 8'hFF); send(8'h33, 8'hFF);
    idle(560);
    chk("R9 rts_n below trigger", rts_n, 0);
    send(8'h34, 8'hFF);
    idle(200);
    chk("R9 rts_n at trigger", rts_n, 1);
    take("R9 pop first");
    chk("R9 rts_n after drain below trigger", rts_n, 0);
    for (int i = 0; i < 3; i++) take("R9 remaining chars");
    chk("R9 rts_n empty", rts_n, 0);

    finish_run();
  end
endmodule